// File: doc/BRIEF.md
# Converter Result Buffer with Word Packing

This block sits between a data converter's result stream and a register-read port. Every cycle it may receive one result from one of five producers: four request channels (source IDs 0 to 3) and one hardware-trigger channel (source ID 4). Each result carries a 12-bit two's-complement sample and a 32-bit timestamp. An admission mask decides which producers are allowed in. Admitted results are stored in one shared memory, which is divided into four circular regions. Request channel k fills region k. The hardware-trigger channel fills a region chosen by configuration.

A reader picks a region and takes words from its head. Three packing formats set how many results one 32-bit read returns: two results per word, one result per word, or one result spread over two words with the timestamp in the second. Each region reports empty, full and threshold status, and has a sticky overflow flag. A bypass mode sends results straight to the read port without touching the memory. A DMA request can be tied either to the threshold status or to the completion strobe of any one producer.

Top module: `adc_result_fifo`

## Requirements
- R1: A result with in_valid high is admitted only when its source is enabled. Mask bit 4 enables source 4 (the hardware-trigger channel). Bits 3, 2, 1 and 0 enable sources 0, 1, 2 and 3 in that order. Source IDs 5 to 7 are never admitted.
- R2: An admitted result from source k (k < 4) goes into region k. A result from source 4 goes into the region named by cfg_ht_region.
- R3: Region k covers memory words cfg_start[k] up to but not including cfg_start[k+1]. The last region ends at the top of memory. Its capacity is that span. Start addresses must rise strictly and may change only while the regions are empty.
- R4: Each region returns its results in the order they were admitted, wrapping within its own span.
- R5: In pack mode 1 (and in the reserved mode 3), one read returns one result. Bits 31:28 hold the 4-bit source tag (zero-extended source ID). Bits 27:0 hold the result sign-extended. rd_valid is high while the region holds at least one result.
- R6: In pack mode 0, one read returns two results. Bits 15:0 hold the older result and bits 31:16 the newer one, each sign-extended to 16 bits. rd_valid is high only when the region holds at least two results, and a read removes both.
- R7: In pack mode 2, the first read returns the mode-1 word and the second read returns the 32-bit timestamp. The result leaves the region only after the second read. The half-select returns to the first word whenever the mode is not 2.
- R8: fifo_empty[k] is high when region k holds nothing. fifo_full[k] is high when region k holds exactly its capacity.
- R9: fifo_thr[k] is high while the occupancy of region k is at least cfg_thr[k].
- R10: A result sent to a full region is dropped, even when a read of that region happens in the same cycle. The drop sets fifo_ovf[k], which stays set until ovf_clr[k] is pulsed. A new drop in the same cycle as the clear wins.
- R11: With cfg_bypass high, admitted results skip the memory. The newest one is held as a mode-1 word and shown with rd_valid. A read clears it. The pack mode is ignored, and region contents and flags do not change.
- R12: With dma_en high, dma_req is a registered copy of the chosen cause. dma_sel values 0 to 4 select "in_valid with that source ID" (admitted or not). Values 5 to 7 select "any fifo_thr bit high".
- R13: rd_en while rd_valid is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Result strobe |
| in_src | input | 3 | Source ID of the result |
| in_result | input | 12 | Two's-complement conversion result |
| in_ts | input | 32 | Timestamp of the result |
| cfg_src_en | input | 5 | Admission mask (bit 4 = source 4, bits 3..0 = sources 0..3) |
| cfg_ht_region | input | 2 | Region used by source 4 |
| cfg_pack_mode | input | 2 | 0 = two per word, 1 = one per word, 2 = two words per result |
| cfg_bypass | input | 1 | Skip the memory |
| cfg_start | input | 28 | Four 7-bit region start addresses, region k at bits 7k+6:7k |
| cfg_thr | input | 28 | Four 7-bit occupancy thresholds, same layout |
| ovf_clr | input | 4 | Per-region overflow flag clear |
| dma_en | input | 1 | DMA request enable |
| dma_sel | input | 3 | DMA request cause |
| rd_region | input | 2 | Region read by the port |
| rd_en | input | 1 | Read strobe, removes data when rd_valid |
| rd_data | output | 32 | Packed read word |
| rd_valid | output | 1 | rd_data is valid |
| fifo_empty | output | 4 | Per-region empty |
| fifo_full | output | 4 | Per-region full |
| fifo_thr | output | 4 | Per-region threshold reached |
| fifo_ovf | output | 4 | Per-region sticky overflow |
| dma_req | output | 1 | DMA request |

## Verification
rd_data and rd_valid are combinational from the region heads, the pack mode and rd_region. They are due in the same cycle the selecting inputs change. Occupancy, the empty, full, threshold and overflow flags, and the half-select all change at the clock edge that samples a write or read, so they are valid one edge after the stimulus. dma_req adds one register and is due one cycle after its cause. The bench drives inputs just after each falling edge, then compares all outputs 1 ns later against a queue model that it advanced at the previous edge. The expected DMA value is carried over by one cycle in that model.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;

    localparam int RES_W   = 12;
    localparam int TS_W    = 32;
    localparam int TAG_W   = 4;
    localparam int SRC_W   = 3;
    localparam int NUM_SRC = 5;
    localparam int HT_SRC  = 4;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [RES_W-1:0] res;
        logic [TS_W-1:0]  ts;
    } entry_t;

    typedef enum logic [1:0] {
        PACK_HALF   = 2'd0,
        PACK_WORD   = 2'd1,
        PACK_DOUBLE = 2'd2,
        PACK_RSVD   = 2'd3
    } pack_mode_e;

    function automatic logic [WORD_W-1:0] fmt_word(input entry_t e);
        return {e.tag, {(WORD_W-TAG_W-RES_W){e.res[RES_W-1]}}, e.res};
    endfunction

    function automatic logic [HALF_W-1:0] fmt_half(input entry_t e);
        return {{(HALF_W-RES_W){e.res[RES_W-1]}}, e.res};
    endfunction

endpackage

// File: rtl/adc_fifo_admit.sv
module adc_fifo_admit
    import adc_fifo_pkg::*;
#(
    parameter int NREG = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SRC_W-1:0]    in_src,
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic [RW-1:0]       ht_region,
    input  logic                bypass,
    output logic [NREG-1:0]     push,
    output logic                byp_load
);

    logic          allowed;
    logic [RW-1:0] dest;

    always_comb begin
        allowed = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (in_src == SRC_W'(s)) begin
                allowed = (s == HT_SRC) ? src_en[HT_SRC] : src_en[HT_SRC-1-s];
            end
        end
    end

    assign dest     = (in_src == SRC_W'(HT_SRC)) ? ht_region : in_src[RW-1:0];
    assign byp_load = in_valid && allowed && bypass;

    always_comb begin
        push = '0;
        if (in_valid && allowed && !bypass) push[dest] = 1'b1;
    end

    p_masked_ht_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_src == SRC_W'(HT_SRC) && !src_en[HT_SRC]) |-> (push == '0 && !byp_load));

    p_bad_src_r1: assert property (@(posedge clk) disable iff (rst)
        (in_src >= SRC_W'(NUM_SRC)) |-> (push == '0 && !byp_load));

    p_one_region_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push));

endmodule

// File: rtl/adc_fifo_region.sv
module adc_fifo_region #(
    parameter int AW  = 7,
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] limit,
    input  logic [AW-1:0] thr,
    input  logic          push,
    input  logic          pop1,
    input  logic          pop2,
    input  logic          ovf_clr,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr0,
    output logic [AW-1:0] rd_addr1,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          thr_hit,
    output logic          ovf,
    output logic          wr_ok
);

    logic [CW-1:0] size;
    logic [CW-1:0] wr_off, rd_off, rd_nxt, rd_nxt2;
    logic [CW-1:0] pop_n;

    function automatic logic [CW-1:0] step(input logic [CW-1:0] o, input logic [CW-1:0] sz);
        return (o + CW'(1) == sz) ? '0 : o + CW'(1);
    endfunction

    assign size     = limit - {1'b0, base};
    assign rd_nxt   = step(rd_off, size);
    assign rd_nxt2  = step(rd_nxt, size);
    assign wr_addr  = base + wr_off[AW-1:0];
    assign rd_addr0 = base + rd_off[AW-1:0];
    assign rd_addr1 = base + rd_nxt[AW-1:0];
    assign empty    = (count == '0);
    assign full     = (count == size);
    assign thr_hit  = (count >= {1'b0, thr});
    assign wr_ok    = push && !full;
    assign pop_n    = pop2 ? CW'(2) : (pop1 ? CW'(1) : CW'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            wr_off <= '0;
            rd_off <= '0;
            ovf    <= 1'b0;
        end else begin
            count <= count + CW'(wr_ok) - pop_n;
            if (wr_ok) wr_off <= step(wr_off, size);
            if (pop2)      rd_off <= rd_nxt2;
            else if (pop1) rd_off <= rd_nxt;
            ovf <= (ovf && !ovf_clr) || (push && full);
        end
    end

    p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
        count <= size);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_drop_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> ovf);

    p_ovf_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

endmodule

// File: rtl/adc_fifo_pack.sv
module adc_fifo_pack
    import adc_fifo_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              bypass,
    input  logic              rd_en,
    input  entry_t            e0,
    input  entry_t            e1,
    input  logic [CW-1:0]     count,
    input  logic              byp_load,
    input  entry_t            byp_entry,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              pop1,
    output logic              pop2
);

    pack_mode_e pm;
    entry_t     hold;
    logic       hold_v;
    logic       phase;
    logic       take;

    assign pm   = pack_mode_e'(mode);
    assign take = rd_en && rd_valid;

    always_comb begin
        if (bypass) begin
            rd_valid = hold_v;
            rd_data  = fmt_word(hold);
        end else begin
            rd_valid = (pm == PACK_HALF) ? (count >= CW'(2)) : (count != '0);
            case (pm)
                PACK_HALF:   rd_data = {fmt_half(e1), fmt_half(e0)};
                PACK_DOUBLE: rd_data = phase ? e0.ts : fmt_word(e0);
                default:     rd_data = fmt_word(e0);
            endcase
        end
    end

    assign pop2 = take && !bypass && (pm == PACK_HALF);
    assign pop1 = take && !bypass && ((pm == PACK_WORD) || (pm == PACK_RSVD) ||
                                      (pm == PACK_DOUBLE && phase));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold   <= '0;
            hold_v <= 1'b0;
            phase  <= 1'b0;
        end else begin
            if (byp_load) begin
                hold   <= byp_entry;
                hold_v <= 1'b1;
            end else if (take && bypass) begin
                hold_v <= 1'b0;
            end
            if (pm != PACK_DOUBLE)      phase <= 1'b0;
            else if (take && !bypass)   phase <= ~phase;
        end
    end

    p_first_half_r7: assert property (@(posedge clk) disable iff (rst)
        (pm == PACK_DOUBLE && !bypass && take && !phase) |=> phase);

    p_no_pop_first_r7: assert property (@(posedge clk) disable iff (rst)
        (pm == PACK_DOUBLE && !phase) |-> !pop1);

    p_pair_avail_r6: assert property (@(posedge clk) disable iff (rst)
        pop2 |-> count >= CW'(2));

    p_hold_load_r11: assert property (@(posedge clk) disable iff (rst)
        byp_load |=> hold_v);

endmodule

// File: rtl/adc_fifo_dma.sv
module adc_fifo_dma
    import adc_fifo_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [2:0]       sel,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_src,
    input  logic [NREG-1:0]  thr_hit,
    output logic             req
);

    logic cause;

    assign cause = (sel < 3'(NUM_SRC)) ? (in_valid && in_src == SRC_W'(sel)) : (|thr_hit);

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= en && cause;
    end

    p_dma_enabled_r12: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(en));

    p_dma_src_r12: assert property (@(posedge clk) disable iff (rst)
        (req && $past(sel) < 3'(NUM_SRC)) |-> $past(in_valid));

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
    import adc_fifo_pkg::*;
#(
    parameter int AW   = 7,
    parameter int NREG = 4,
    localparam int DEPTH = 1 << AW,
    localparam int CW    = AW + 1,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SRC_W-1:0]     in_src,
    input  logic [RES_W-1:0]     in_result,
    input  logic [TS_W-1:0]      in_ts,
    input  logic [NUM_SRC-1:0]   cfg_src_en,
    input  logic [RW-1:0]        cfg_ht_region,
    input  logic [1:0]           cfg_pack_mode,
    input  logic                 cfg_bypass,
    input  logic [NREG*AW-1:0]   cfg_start,
    input  logic [NREG*AW-1:0]   cfg_thr,
    input  logic [NREG-1:0]      ovf_clr,
    input  logic                 dma_en,
    input  logic [2:0]           dma_sel,
    input  logic [RW-1:0]        rd_region,
    input  logic                 rd_en,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [NREG-1:0]      fifo_empty,
    output logic [NREG-1:0]      fifo_full,
    output logic [NREG-1:0]      fifo_thr,
    output logic [NREG-1:0]      fifo_ovf,
    output logic                 dma_req
);

    entry_t         mem [DEPTH];
    entry_t         in_entry;
    logic [NREG-1:0] push, wr_ok;
    logic            byp_load;
    logic [AW-1:0]   wr_addr  [NREG];
    logic [AW-1:0]   rd_addr0 [NREG];
    logic [AW-1:0]   rd_addr1 [NREG];
    logic [CW-1:0]   count    [NREG];
    logic [NREG*CW-1:0] cnt_all;
    logic            pop1, pop2;
    logic            we;
    logic [AW-1:0]   wa;

    assign in_entry = '{tag: TAG_W'(in_src), res: in_result, ts: in_ts};

    adc_fifo_admit #(.NREG(NREG)) u_admit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_src    (in_src),
        .src_en    (cfg_src_en),
        .ht_region (cfg_ht_region),
        .bypass    (cfg_bypass),
        .push      (push),
        .byp_load  (byp_load)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_region
        logic [CW-1:0] limit;
        if (k == NREG - 1) begin : g_last
            assign limit = CW'(DEPTH);
        end else begin : g_mid
            assign limit = {1'b0, cfg_start[(k+1)*AW +: AW]};
        end

        adc_fifo_region #(.AW(AW)) u_region (
            .clk      (clk),
            .rst      (rst),
            .base     (cfg_start[k*AW +: AW]),
            .limit    (limit),
            .thr      (cfg_thr[k*AW +: AW]),
            .push     (push[k]),
            .pop1     (pop1 && rd_region == RW'(k)),
            .pop2     (pop2 && rd_region == RW'(k)),
            .ovf_clr  (ovf_clr[k]),
            .wr_addr  (wr_addr[k]),
            .rd_addr0 (rd_addr0[k]),
            .rd_addr1 (rd_addr1[k]),
            .count    (count[k]),
            .empty    (fifo_empty[k]),
            .full     (fifo_full[k]),
            .thr_hit  (fifo_thr[k]),
            .ovf      (fifo_ovf[k]),
            .wr_ok    (wr_ok[k])
        );

        assign cnt_all[k*CW +: CW] = count[k];
    end

    always_comb begin
        we = 1'b0;
        wa = '0;
        for (int k = 0; k < NREG; k++) begin
            if (wr_ok[k]) begin
                we = 1'b1;
                wa = wr_addr[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= in_entry;
    end

    adc_fifo_pack #(.CW(CW)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_pack_mode),
        .bypass    (cfg_bypass),
        .rd_en     (rd_en),
        .e0        (mem[rd_addr0[rd_region]]),
        .e1        (mem[rd_addr1[rd_region]]),
        .count     (count[rd_region]),
        .byp_load  (byp_load),
        .byp_entry (in_entry),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .pop1      (pop1),
        .pop2      (pop2)
    );

    adc_fifo_dma #(.NREG(NREG)) u_dma (
        .clk      (clk),
        .rst      (rst),
        .en       (dma_en),
        .sel      (dma_sel),
        .in_valid (in_valid),
        .in_src   (in_src),
        .thr_hit  (fifo_thr),
        .req      (dma_req)
    );

    p_bypass_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |=> $stable(cnt_all));

    p_idle_read_r13: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !rd_valid) |=> $stable(cnt_all));

endmodule

// File: tb/adc_result_fifo_bench.sv
module adc_result_fifo_bench;
    import adc_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_src;
    logic [11:0] in_result;
    logic [31:0] in_ts;
    logic [4:0]  cfg_src_en;
    logic [1:0]  cfg_ht_region;
    logic [1:0]  cfg_pack_mode;
    logic        cfg_bypass;
    logic [27:0] cfg_start;
    logic [27:0] cfg_thr;
    logic [3:0]  ovf_clr;
    logic        dma_en;
    logic [2:0]  dma_sel;
    logic [1:0]  rd_region;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  fifo_empty, fifo_full, fifo_thr, fifo_ovf;
    logic        dma_req;

    always #2 clk = ~clk;

    adc_result_fifo u_adc_result_fifo (.*);

    int     n_checks = 0;
    int     n_fail   = 0;
    bit     done     = 0;
    int     cap [4]  = '{16, 24, 56, 32};
    int     thr [4]  = '{4, 10, 20, 8};
    entry_t q   [4][$];
    bit     m_ovf [4];
    bit     m_phase;
    entry_t m_hold;
    bit     m_hold_v;
    bit     m_dma;

    function automatic logic [31:0] w_full(entry_t e);
        return {e.tag, {16{e.res[11]}}, e.res};
    endfunction

    function automatic logic [15:0] w_half(entry_t e);
        return {{4{e.res[11]}}, e.res};
    endfunction

    function automatic bit src_ok(logic [2:0] s, logic [4:0] m);
        if (s > 3'd4) return 0;
        if (s == 3'd4) return m[4];
        return m[3 - s];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int      r;
        bit      ev;
        logic [31:0] ed;
        string   tag;
        r = int'(rd_region);
        if (cfg_bypass) begin
            ev = m_hold_v; ed = w_full(m_hold); tag = "R11 bypass data";
        end else if (cfg_pack_mode == 2'd0) begin
            ev = q[r].size() >= 2;
            ed = ev ? {w_half(q[r][1]), w_half(q[r][0])} : '0;
            tag = "R6 pair pack";
        end else if (cfg_pack_mode == 2'd2) begin
            ev = q[r].size() >= 1;
            ed = ev ? (m_phase ? q[r][0].ts : w_full(q[r][0])) : '0;
            tag = "R7 two-word pack";
        end else begin
            ev = q[r].size() >= 1;
            ed = ev ? w_full(q[r][0]) : '0;
            tag = "R5 word pack / R4 order";
        end
        chk({tag, " valid"}, 32'(rd_valid), 32'(ev));
        if (ev) chk(tag, rd_data, ed);
        for (int k = 0; k < 4; k++) begin
            chk("R8 empty", 32'(fifo_empty[k]), 32'(q[k].size() == 0));
            chk("R8 full / R3 capacity", 32'(fifo_full[k]), 32'(q[k].size() == cap[k]));
            chk("R9 threshold", 32'(fifo_thr[k]), 32'(q[k].size() >= thr[k]));
            chk("R10 overflow", 32'(fifo_ovf[k]), 32'(m_ovf[k]));
        end
        chk("R12 dma", 32'(dma_req), 32'(m_dma));
    endtask

    task automatic advance();
        int     r, d;
        bit     ev, anythr, full_pre [4];
        entry_t e;
        r = int'(rd_region);
        anythr = 0;
        for (int k = 0; k < 4; k++) begin
            anythr |= (q[k].size() >= thr[k]);
            full_pre[k] = (q[k].size() == cap[k]);
        end
        if (cfg_bypass) ev = m_hold_v;
        else if (cfg_pack_mode == 2'd0) ev = q[r].size() >= 2;
        else ev = q[r].size() >= 1;
        // R12 expectation for the next cycle
        m_dma = dma_en && ((dma_sel < 3'd5) ? (in_valid && in_src == dma_sel) : anythr);
        for (int k = 0; k < 4; k++) if (ovf_clr[k]) m_ovf[k] = 0;
        // R13: reads only act when valid
        if (rd_en && ev) begin
            if (cfg_bypass) m_hold_v = 0;
            else if (cfg_pack_mode == 2'd0) begin void'(q[r].pop_front()); void'(q[r].pop_front()); end
            else if (cfg_pack_mode == 2'd2) begin
                if (m_phase) void'(q[r].pop_front());
                m_phase = !m_phase;
            end else void'(q[r].pop_front());
        end
        if (cfg_pack_mode != 2'd2) m_phase = 0;
        // R1, R2 admission and routing
        if (in_valid && src_ok(in_src, cfg_src_en)) begin
            e = '{tag: {1'b0, in_src}, res: in_result, ts: in_ts};
            d = (in_src == 3'd4) ? int'(cfg_ht_region) : int'(in_src);
            if (cfg_bypass) begin m_hold = e; m_hold_v = 1; end
            else if (full_pre[d]) m_ovf[d] = 1;
            else q[d].push_back(e);
        end
    endtask

    task automatic run(int cycles, int wp, int rp, logic [1:0] mode, bit byp,
                       logic [4:0] mask, logic [1:0] ht, logic [2:0] dsel, bit den);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            cfg_pack_mode = mode; cfg_bypass = byp; cfg_src_en = mask;
            cfg_ht_region = ht; dma_sel = dsel; dma_en = den;
            in_valid  = ($urandom % 100) < wp;
            in_src    = 3'($urandom % 8);
            in_result = 12'($urandom);
            in_ts     = $urandom;
            rd_en     = ($urandom % 100) < rp;
            rd_region = 2'($urandom % 4);
            ovf_clr   = (($urandom % 40) == 0) ? 4'($urandom) : 4'h0;
            #1;
            compare();
            advance();
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst = 1; in_valid = 0; in_src = 0; in_result = 0; in_ts = 0;
        cfg_src_en = 5'h1F; cfg_ht_region = 0; cfg_pack_mode = 2'd1; cfg_bypass = 0;
        cfg_start = {7'd96, 7'd40, 7'd16, 7'd0};
        cfg_thr   = {7'd8, 7'd20, 7'd10, 7'd4};
        ovf_clr = 0; dma_en = 0; dma_sel = 0; rd_region = 0; rd_en = 0;
        m_phase = 0; m_hold = '0; m_hold_v = 0; m_dma = 0;
        for (int k = 0; k < 4; k++) m_ovf[k] = 0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // reset state: all regions empty, nothing valid, no flags, no request
        chk("R8 reset empty", 32'(fifo_empty), 32'hF);
        chk("R8 reset full", 32'(fifo_full), 32'h0);
        chk("R10 reset ovf", 32'(fifo_ovf), 32'h0);
        chk("R5 reset valid", 32'(rd_valid), 32'h0);
        chk("R12 reset dma", 32'(dma_req), 32'h0);
        // R13 directed: read of an empty region, then check nothing moved
        @(negedge clk); rd_en = 1; rd_region = 2'd2; #1; compare(); advance();
        // R5 / R4 one result per word, all sources
        run(1500, 50, 40, 2'd1, 0, 5'h1F, 2'd3, 3'd2, 1);
        // R6 pairs
        run(1500, 50, 30, 2'd0, 0, 5'h1F, 2'd1, 3'd4, 1);
        // R7 two-word mode
        run(1500, 50, 50, 2'd2, 0, 5'h1F, 2'd0, 3'd6, 1);
        // R1 partial mask, reserved mode 3
        run(1500, 60, 40, 2'd3, 0, 5'b10101, 2'd2, 3'd0, 1);
        // R10 fill with no reads until regions overflow
        run(600, 100, 0, 2'd1, 0, 5'h1F, 2'd0, 3'd5, 1);
        // drain and clear
        run(800, 10, 90, 2'd1, 0, 5'h1F, 2'd0, 3'd5, 1);
        // R11 bypass
        run(800, 40, 40, 2'd0, 1, 5'h1F, 2'd1, 3'd1, 1);
        // R12 with requests disabled, mixed modes afterwards
        run(800, 50, 50, 2'd2, 0, 5'h0F, 2'd3, 3'd3, 0);
        run(1500, 55, 45, 2'd0, 0, 5'h1F, 2'd2, 3'd7, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule